// File: doc/BRIEF.md
# Partitioned SIMD Bit-Field Slicer

The slicer takes a 64-bit packed SIMD word whose element width is chosen at run time (8, 16, 32 or 64 bits). It cuts the same bit range out of every element and packs the pieces into a narrow output word. The output is a grid of eight slots, one for each 8-bit lane position. Every slot is exactly as wide as the slice. An element wider than one lane drops its piece into the lowest slot of the lanes it covers. The other slots of that group are padding and are driven to zero. An 8-bit mask beside the data marks the slots that carry a real piece.

The slice bounds are elaboration-time parameters. They must lie inside the smallest element, so `0 <= SLICE_LO < SLICE_HI <= 8`, and elaboration stops with an error if they do not. Because the slot grid never changes, a consumer reads slot j at the same output bits in every mode and uses the mask to tell data from padding. With the default bounds (bits 3 to 5) the output is 24 bits wide. An optional output register, selected by a parameter and on by default, adds one cycle of latency and is cleared by a synchronous active-high reset.

Top module: `bitfield_slicer`

## Requirements
- R1: With `width_sel` = 2'b00 (8-bit elements), slot j (output bits [3j, 3j+3)) holds input bits [8j+3, 8j+6), for all eight slots.
- R2: With `width_sel` = 2'b01 (16-bit elements), element k (input bits [16k, 16k+16)) places its bits [3, 6) in slot 2k, which is output bits [6k, 6k+3).
- R3: Every slot that carries no element piece (a slot whose mask bit is 0) reads as all zeros.
- R4: With `width_sel` = 2'b10 (32-bit elements), element k places its bits [3, 6) in slot 4k, which is output bits [12k, 12k+3).
- R5: With `width_sel` = 2'b11 (64-bit element), slot 0 (output bits [0, 3)) holds input bits [3, 6), and slots 1 to 7 are padding.
- R6: `slot_valid` bit j is 1 exactly when slot j carries data: 8'hFF, 8'h55, 8'h11 and 8'h01 for width codes 00, 01, 10 and 11.
- R7: With the output register on, `slots_out` and `slot_valid` show the result for the inputs sampled at the previous rising clock edge, and they hold until the next edge.
- R8: While `rst` is high at a rising edge, the register clears both `slots_out` and `slot_valid` to zero.
- R9: Input bits outside the slice range of every element have no effect on either output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| width_sel | input | 2 | Element width code: 00 = 8, 01 = 16, 10 = 32, 11 = 64 bits |
| word_in | input | 64 | Packed SIMD input word |
| slots_out | output | 24 | Eight slots of 3 bits each; slot j at bits [3j, 3j+3) |
| slot_valid | output | 8 | Bit j is 1 when slot j carries data |

## Verification
The data path and the mask path can both change at the same clock edge. This happens when the width code and the input word change together, and the register must then switch the mask and the padding pattern at the same moment as the new slice data. The bench provokes this by changing `width_sel` and `word_in` on every cycle of a long random run. After each edge it compares both outputs against a reference that rebuilds the expected slots element by element. A reset that arrives while data and mode are changing is the second collision: the bench drives it in the middle of traffic, expects all zeros for that cycle, and expects normal results on the cycle after.

// File: rtl/simd_slice_pkg.sv
`timescale 1ns/1ps
package simd_slice_pkg;

    // Element width code carried on width_sel.
    typedef enum logic [1:0] {
        EW_8  = 2'b00,
        EW_16 = 2'b01,
        EW_32 = 2'b10,
        EW_64 = 2'b11
    } elem_width_e;

    // Number of narrowest lanes that one element of the given width covers.
    function automatic int unsigned lanes_per_elem(elem_width_e w);
        return 32'd1 << w;
    endfunction

    // True when slot index s is the lowest lane of its element group.
    function automatic logic slot_carries(int unsigned s, elem_width_e w);
        return (s % lanes_per_elem(w)) == 0;
    endfunction

    // Mask of word bits that some slice reads, for a given lane geometry.
    function automatic logic [1023:0] read_bits_mask(int unsigned word_w,
                                                     int unsigned lane_w,
                                                     int unsigned lo,
                                                     int unsigned hi);
        logic [1023:0] m;
        m = '0;
        for (int unsigned b = 0; b < word_w; b++) begin
            if ((b % lane_w) >= lo && (b % lane_w) < hi) begin
                m[b] = 1'b1;
            end
        end
        return m;
    endfunction

endpackage

// File: rtl/lane_extract.sv
`timescale 1ns/1ps
module lane_extract #(
    parameter int unsigned WORD_W   = 64,
    parameter int unsigned LANE_W   = 8,
    parameter int unsigned SLICE_LO = 3,
    parameter int unsigned SLICE_HI = 6,
    localparam int unsigned NSLOT   = WORD_W / LANE_W,
    localparam int unsigned SW      = SLICE_HI - SLICE_LO
) (
    input  logic [WORD_W-1:0]   word_in,
    output logic [NSLOT*SW-1:0] raw_slots
);
    import simd_slice_pkg::*;

    localparam logic [1023:0] READ_MASK_WIDE =
        read_bits_mask(WORD_W, LANE_W, SLICE_LO, SLICE_HI);
    localparam logic [WORD_W-1:0] READ_MASK = READ_MASK_WIDE[WORD_W-1:0];

    // Every lane position yields the slice taken from its own base bit.
    // For a wide element the lowest lane base equals the element base.
    for (genvar j = 0; j < NSLOT; j++) begin : g_lane
        assign raw_slots[j*SW +: SW] = word_in[j*LANE_W + SLICE_LO +: SW];
    end

    // Bits outside every slice are deliberately left out of the datapath.
    logic unused_outside;
    assign unused_outside = ^(word_in & ~READ_MASK);

endmodule

// File: rtl/slot_placer.sv
`timescale 1ns/1ps
module slot_placer #(
    parameter int unsigned NSLOT = 8,
    parameter int unsigned SW    = 3
) (
    input  simd_slice_pkg::elem_width_e width,
    input  logic [NSLOT*SW-1:0]         raw_slots,
    output logic [NSLOT*SW-1:0]         placed_slots,
    output logic [NSLOT-1:0]            carrier_mask
);
    import simd_slice_pkg::*;

    for (genvar j = 0; j < NSLOT; j++) begin : g_slot
        logic keep;
        always_comb begin
            keep = slot_carries(j, width);
        end
        assign carrier_mask[j]          = keep;
        assign placed_slots[j*SW +: SW] = keep ? raw_slots[j*SW +: SW] : '0;
    end

endmodule

// File: rtl/slicer_stage.sv
`timescale 1ns/1ps
module slicer_stage #(
    parameter int unsigned DW         = 32,
    parameter bit          REGISTERED = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] d,
    output logic [DW-1:0] q
);
    if (REGISTERED) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else begin
                q <= d;
            end
        end
    end else begin : g_thru
        assign q = d;
        logic unused_ctrl;
        assign unused_ctrl = clk ^ rst;
    end

endmodule

// File: rtl/bitfield_slicer.sv
`timescale 1ns/1ps
module bitfield_slicer #(
    parameter int unsigned WORD_W       = 64,
    parameter int unsigned LANE_W       = 8,
    parameter int unsigned SLICE_LO     = 3,
    parameter int unsigned SLICE_HI     = 6,
    parameter bit          REGISTER_OUT = 1'b1,
    localparam int unsigned NSLOT       = WORD_W / LANE_W,
    localparam int unsigned SW          = SLICE_HI - SLICE_LO,
    localparam int unsigned OUT_W       = NSLOT * SW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        width_sel,
    input  logic [WORD_W-1:0] word_in,
    output logic [OUT_W-1:0]  slots_out,
    output logic [NSLOT-1:0]  slot_valid
);
    import simd_slice_pkg::*;

    // Parameter legality: slice inside the narrowest lane, eight-lane grid.
    if (!(SLICE_LO < SLICE_HI && SLICE_HI <= LANE_W)) begin : g_bad_bounds
        $error("bitfield_slicer: slice bounds must satisfy LO < HI <= LANE_W");
    end
    if (NSLOT != 8 || WORD_W % LANE_W != 0) begin : g_bad_grid
        $error("bitfield_slicer: word must split into exactly eight lanes");
    end

    typedef struct packed {
        logic [OUT_W-1:0] data;
        logic [NSLOT-1:0] mask;
    } slicer_res_t;

    elem_width_e      width;
    logic [OUT_W-1:0] raw_slots;
    slicer_res_t      res_d;
    slicer_res_t      res_q;

    assign width = elem_width_e'(width_sel);

    lane_extract #(
        .WORD_W  (WORD_W),
        .LANE_W  (LANE_W),
        .SLICE_LO(SLICE_LO),
        .SLICE_HI(SLICE_HI)
    ) u_extract (
        .word_in  (word_in),
        .raw_slots(raw_slots)
    );

    slot_placer #(
        .NSLOT(NSLOT),
        .SW   (SW)
    ) u_place (
        .width       (width),
        .raw_slots   (raw_slots),
        .placed_slots(res_d.data),
        .carrier_mask(res_d.mask)
    );

    slicer_stage #(
        .DW        ($bits(slicer_res_t)),
        .REGISTERED(REGISTER_OUT)
    ) u_stage (
        .clk(clk),
        .rst(rst),
        .d  (res_d),
        .q  (res_q)
    );

    assign slots_out  = res_q.data;
    assign slot_valid = res_q.mask;

endmodule

// File: rtl/slicer_checker.sv
`timescale 1ns/1ps
module slicer_checker #(
    parameter int unsigned NSLOT = 8,
    parameter int unsigned SW    = 3,
    parameter bit          REG   = 1'b1
) (
    input logic               clk,
    input logic               rst,
    input logic [1:0]         width_sel,
    input logic [SW-1:0]      lane0_slice,
    input logic [NSLOT*SW-1:0] slots_out,
    input logic [NSLOT-1:0]   slot_valid
);
    // R3: a slot flagged as padding carries zeros.
    for (genvar j = 0; j < NSLOT; j++) begin : g_pad
        a_r3_pad_zero: assert property (@(posedge clk) disable iff (rst)
            !slot_valid[j] |-> slots_out[j*SW +: SW] == '0);
    end

    if (REG) begin : g_reg
        // R6: number of carrying slots follows the width code sampled before.
        a_r6_mask_count: assert property (@(posedge clk) disable iff (rst)
            !$past(rst) |-> $countones(slot_valid) == (32'd8 >> $past(width_sel)));
        // R1/R5: slot 0 always carries the slice of the lowest element.
        a_r5_slot0_data: assert property (@(posedge clk) disable iff (rst)
            !$past(rst) |-> (slot_valid[0] && slots_out[SW-1:0] == $past(lane0_slice)));
        // R5: full-width mode leaves only slot 0 flagged.
        a_r5_single_mask: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $past(width_sel) == 2'b11) |-> slot_valid == 8'h01);
        // R8: a reset edge leaves the outputs cleared on the next cycle.
        a_r8_reset_clear: assert property (@(posedge clk) disable iff (rst)
            $past(rst) |-> (slots_out == '0 && slot_valid == '0));
    end else begin : g_comb
        a_r6_mask_count: assert property (@(posedge clk) disable iff (rst)
            $countones(slot_valid) == (32'd8 >> width_sel));
        a_r5_slot0_data: assert property (@(posedge clk) disable iff (rst)
            slot_valid[0] && slots_out[SW-1:0] == lane0_slice);
        a_r5_single_mask: assert property (@(posedge clk) disable iff (rst)
            width_sel == 2'b11 |-> slot_valid == 8'h01);
    end

endmodule

bind bitfield_slicer slicer_checker #(
    .NSLOT(NSLOT),
    .SW   (SW),
    .REG  (REGISTER_OUT)
) u_slicer_checker (
    .clk        (clk),
    .rst        (rst),
    .width_sel  (width_sel),
    .lane0_slice(word_in[SLICE_HI-1:SLICE_LO]),
    .slots_out  (slots_out),
    .slot_valid (slot_valid)
);

// File: tb/test_bitfield_slicer.sv
`timescale 1ns/1ps
module test_bitfield_slicer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  width_sel = 2'b00;
    logic [63:0] word_in = '0;
    logic [23:0] slots_out;
    logic [7:0]  slot_valid;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    bitfield_slicer #(
        .WORD_W(64), .LANE_W(8), .SLICE_LO(3), .SLICE_HI(6), .REGISTER_OUT(1'b1)
    ) i_bitfield_slicer (
        .clk(clk), .rst(rst), .width_sel(width_sel), .word_in(word_in),
        .slots_out(slots_out), .slot_valid(slot_valid)
    );

    // Reference: walk the elements and drop each slice at its lane base.
    function automatic logic [23:0] ref_data(logic [63:0] w, logic [1:0] sel);
        logic [23:0] r = '0;
        int ew = 8 << sel;
        for (int k = 0; k < 64 / ew; k++) begin
            int slot = (k * ew) / 8;
            r[slot*3 +: 3] = w[k*ew + 3 +: 3];
        end
        return r;
    endfunction

    function automatic logic [7:0] ref_mask(logic [1:0] sel);
        logic [7:0] m = '0;
        int ew = 8 << sel;
        for (int k = 0; k < 64 / ew; k++) m[(k * ew) / 8] = 1'b1;
        return m;
    endfunction

    function automatic string mode_tag(logic [1:0] sel);
        case (sel)
            2'b00:   return "R1";
            2'b01:   return "R2";
            2'b10:   return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive at a falling edge, let one rising edge pass, compare at the next fall.
    task automatic step(logic [63:0] w, logic [1:0] sel, logic r);
        logic [23:0] ed;
        logic [7:0]  em;
        logic [23:0] padbits;
        word_in = w; width_sel = sel; rst = r;
        @(negedge clk);
        ed = r ? 24'h0 : ref_data(w, sel);
        em = r ? 8'h0  : ref_mask(sel);
        if (r) begin
            check("R8 data", {8'h0, slots_out}, {8'h0, ed});
            check("R8 mask", {24'h0, slot_valid}, {24'h0, em});
        end else begin
            check({mode_tag(sel), " data"}, {8'h0, slots_out}, {8'h0, ed});
            check("R6 mask", {24'h0, slot_valid}, {24'h0, em});
            padbits = '0;
            for (int j = 0; j < 8; j++) if (!em[j]) padbits[j*3 +: 3] = 3'b111;
            check("R3 padding", {8'h0, slots_out & padbits}, 32'h0);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : stim
        logic [23:0] held_d;
        logic [7:0]  held_m;
        repeat (3) @(negedge clk);
        // R8: outputs cleared while reset is held.
        check("R8 reset data", {8'h0, slots_out}, 32'h0);
        check("R8 reset mask", {24'h0, slot_valid}, 32'h0);

        // Directed patterns in every mode.
        for (int s = 0; s < 4; s++) begin
            step(64'h0123_4567_89AB_CDEF, 2'(s), 1'b0);
            step(64'hFFFF_FFFF_FFFF_FFFF, 2'(s), 1'b0);
            step(64'h3838_3838_3838_3838, 2'(s), 1'b0);
            step(64'hA5C3_0F96_5A3C_F069, 2'(s), 1'b0);
        end

        // R7: new input is not visible before the rising edge, then holds.
        step(64'h0000_0000_0000_0028, 2'b00, 1'b0);
        held_d = slots_out; held_m = slot_valid;
        word_in = 64'hFFFF_FFFF_FFFF_FFFF; width_sel = 2'b11;
        #1;
        check("R7 hold data", {8'h0, slots_out}, {8'h0, held_d});
        check("R7 hold mask", {24'h0, slot_valid}, {24'h0, held_m});
        @(negedge clk);
        check("R7 update data", {8'h0, slots_out}, {8'h0, ref_data(word_in, 2'b11)});

        // R9: toggling every bit outside the slices leaves outputs unchanged.
        for (int s = 0; s < 4; s++) begin
            step(64'h5A5A_5A5A_5A5A_5A5A, 2'(s), 1'b0);
            held_d = slots_out; held_m = slot_valid;
            word_in = 64'h5A5A_5A5A_5A5A_5A5A ^ 64'hC7C7_C7C7_C7C7_C7C7;
            @(negedge clk);
            check("R9 outside bits data", {8'h0, slots_out}, {8'h0, held_d});
            check("R9 outside bits mask", {24'h0, slot_valid}, {24'h0, held_m});
        end

        // Mode and data change together every cycle, with resets mid-stream.
        for (int i = 0; i < 400; i++) begin
            step({$urandom, $urandom}, 2'($urandom_range(0, 3)),
                 (i % 97) == 50);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule